// File: doc/BRIEF.md
# Command-Driven Byte Store Register Interface

This block gives a host access to a 256-location byte store through three 8-bit registers: a data register, an address register and a control/status register. The host loads the address, fills the data register when it wants to store, then writes the control register with the start bit set and the direction bit chosen. The block runs exactly one byte transfer and holds a busy flag for the whole transfer. On a fetch, the fetched byte appears in the data register, and the host may read it once busy has dropped.

The store is an internal array that reset does not clear. A parameterised number of cycles stands in for the access time of a slow nonvolatile device: one count for stores and another for fetches. Host access uses a plain single-cycle register port, because each access completes in the cycle it is presented and the busy flag already paces the host. There is therefore no valid/ready handshake and no back-pressure. Writes that arrive while a transfer is running are dropped, so the running transfer cannot be disturbed.

Top module: `byte_store_regif`

## Requirements
- R1: The address register is 8 bits wide and selects one of 256 byte locations, so locations 0x00 and 0xFF hold independent values.
- R2: Register select 0 is the data register, 1 is the address register, 2 is control/status, and 3 reads 0x00. In control/status, bit 7 is start, bit 6 is direction, bit 5 is busy, and bits 4:0 read as zero. The start bit always reads back as 0.
- R3: Direction 0 is a store: the data register value is written to the array at the address register value. Direction 1 is a fetch.
- R4: A control write with bit 7 set while idle begins exactly one transfer. A control write with bit 7 clear only records the direction and starts nothing.
- R5: Busy is high for exactly WRITE_CYCLES cycles on a store and READ_CYCLES cycles on a fetch. The count starts at the clock edge that accepts the start.
- R6: At the end of a fetch, the data register holds the byte at the fetched address, valid from the cycle busy is low.
- R7: While busy is high, writes to the data, address and control registers are ignored, including a second start.
- R8: Reset, including a reset in the middle of a transfer, clears busy, direction, the data register and the address register. Array contents survive reset.
- R9: Values written to the data and address registers while idle read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 data, 1 address, 2 control/status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | High while a transfer runs |

## Verification
The bench sends writes to all three registers in the middle of a store and then confirms that the address, data and direction are unchanged and that the stored byte is the original one. A design that let those writes through would store the wrong byte or start a fetch. It writes the control register with start clear and expects no busy, which catches a decoder that triggers on any control write. It measures the busy length of both operations against the two parameters, which catches off-by-one counters. It places bytes at both address extremes, overwrites a location, and applies a reset during a transfer. A design that aliased addresses, cleared the array on reset, or left busy stuck would return the wrong bytes or fail to go idle.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CTL_START = 7;
  localparam int CTL_DIR   = 6;
  localparam int CTL_BUSY  = 5;

  localparam logic DIR_STORE = 1'b0;
  localparam logic DIR_FETCH = 1'b1;
endpackage

// File: rtl/bsr_sequencer.sv
module bsr_sequencer #(
  parameter int WRITE_CYCLES = 6,
  parameter int READ_CYCLES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic start_dir,
  output logic busy,
  output logic done
);
  localparam int MAX_CYC = (WRITE_CYCLES > READ_CYCLES) ? WRITE_CYCLES : READ_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // the transfer completes on the edge where the remaining count is zero
  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_req) begin
      busy_q <= 1'b1;
      cnt_q  <= start_dir ? RD_LOAD : WR_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // no reset on purpose: the contents model nonvolatile storage
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bsr_host_regs.sv
module bsr_host_regs
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              fetch_done,
  input  logic [REG_W-1:0]  fetch_byte,
  output logic              start_req,
  output logic [ADDR_W-1:0] addr_q,
  output logic [REG_W-1:0]  data_q,
  output logic              dir_q,
  output logic [REG_W-1:0]  reg_rdata
);
  logic host_wr;
  logic wr_data, wr_addr, wr_ctrl;

  // writes are accepted only while idle
  assign host_wr   = reg_wr && !busy;
  assign wr_data   = host_wr && (reg_sel == SEL_DATA);
  assign wr_addr   = host_wr && (reg_sel == SEL_ADDR);
  assign wr_ctrl   = host_wr && (reg_sel == SEL_CTRL);
  assign start_req = wr_ctrl && reg_wdata[CTL_START];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      addr_q <= '0;
      dir_q  <= DIR_STORE;
    end else begin
      if (fetch_done) begin
        data_q <= fetch_byte;
      end else if (wr_data) begin
        data_q <= reg_wdata;
      end
      if (wr_addr) begin
        addr_q <= reg_wdata[ADDR_W-1:0];
      end
      if (wr_ctrl) begin
        dir_q <= reg_wdata[CTL_DIR];
      end
    end
  end

  logic [REG_W-1:0] ctrl_view;

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[CTL_DIR]  = dir_q;
    ctrl_view[CTL_BUSY] = busy;
  end

  always_comb begin
    unique case (reg_sel)
      SEL_DATA: reg_rdata = data_q;
      SEL_ADDR: reg_rdata = REG_W'(addr_q);
      SEL_CTRL: reg_rdata = ctrl_view;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/byte_store_regif.sv
module byte_store_regif
  import bsr_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 6,
  parameter int READ_CYCLES  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy
);
  logic              start_req;
  logic              done;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  data_q;
  logic [REG_W-1:0]  array_rdata;
  logic              store_we;
  logic              fetch_done;

  assign store_we   = done && (dir_q == DIR_STORE);
  assign fetch_done = done && (dir_q == DIR_FETCH);

  bsr_host_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .fetch_done (fetch_done),
    .fetch_byte (array_rdata),
    .start_req  (start_req),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .dir_q      (dir_q),
    .reg_rdata  (reg_rdata)
  );

  bsr_sequencer #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .READ_CYCLES  (READ_CYCLES)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .start_dir (reg_wdata[CTL_DIR]),
    .busy      (busy),
    .done      (done)
  );

  bsr_array #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) array_i (
    .clk   (clk),
    .we    (store_we),
    .addr  (addr_q),
    .wdata (data_q),
    .rdata (array_rdata)
  );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int ADDR_W       = 8,
  parameter int WRITE_CYCLES = 6,
  parameter int READ_CYCLES  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic              wr_start,
  input logic [7:0]        reg_rdata,
  input logic              busy,
  input logic              dir_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [7:0]        data_q
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 16'd1;
    else           run_len <= '0;
  end

  // R2
  ctrl_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> (reg_rdata[4:0] == 5'd0 && !reg_rdata[7]
                           && reg_rdata[5] == busy && reg_rdata[6] == dir_q));

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_sel == 2'd2 && wr_start));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (dir_q ? 16'(READ_CYCLES) : 16'(WRITE_CYCLES))));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> ($stable(addr_q) && $stable(dir_q)));

  // R7
  busy_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_q && reg_wr) |=> $stable(data_q));

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!busy && !dir_q));
endmodule

bind byte_store_regif bsr_checker #(
  .ADDR_W       (ADDR_W),
  .WRITE_CYCLES (WRITE_CYCLES),
  .READ_CYCLES  (READ_CYCLES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .wr_start  (reg_wdata[7]),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .dir_q     (dir_q),
  .addr_q    (addr_q),
  .data_q    (data_q)
);

// File: tb/byte_store_regif_tb.sv
`timescale 1ns/1ps
module byte_store_regif_tb_top;
  localparam int WR_CYC = 6;
  localparam int RD_CYC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  byte_store_regif #(
    .ADDR_W(8), .WRITE_CYCLES(WR_CYC), .READ_CYCLES(RD_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
  );

  // {kind(1=fetch), addr, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h00, 8'hA5},
    {1'b0, 8'hFF, 8'h3C},
    {1'b0, 8'h7E, 8'h81},
    {1'b1, 8'h00, 8'hA5},
    {1'b1, 8'hFF, 8'h3C},
    {1'b0, 8'h00, 8'h5A},
    {1'b1, 8'h00, 8'h5A},
    {1'b1, 8'h7E, 8'h81}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  // called at the negedge right after the accepting edge
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_store(input logic [7:0] a, input logic [7:0] d, input bit measure);
    logic [7:0] v;
    int n;
    wr(2'd0, d);
    wr(2'd1, a);
    wr(2'd2, 8'h80);
    rd(2'd2, v);
    chk("R2 ctrl during store", v, 8'h20);
    busy_len(n);
    if (measure) chk("R5 store busy length", n, WR_CYC);
  endtask

  task automatic do_fetch(input logic [7:0] a, output logic [7:0] d, output int n);
    logic [7:0] v;
    wr(2'd1, a);
    wr(2'd2, 8'hC0);
    rd(2'd2, v);
    chk("R2 ctrl during fetch", v, 8'h60);
    busy_len(n);
    rd(2'd0, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    chk("R8 busy after reset", busy, 0);
    rd(2'd2, v); chk("R8 ctrl after reset", v, 8'h00);
    rd(2'd0, v); chk("R8 data after reset", v, 8'h00);
    rd(2'd1, v); chk("R8 addr after reset", v, 8'h00);
    rd(2'd3, v); chk("R2 select 3 reads zero", v, 8'h00);

    // vector table: R1 R3 R5 R6
    foreach (VEC[i]) begin
      if (!VEC[i][16]) begin
        do_store(VEC[i][15:8], VEC[i][7:0], 1'b1);
      end else begin
        do_fetch(VEC[i][15:8], v, n);
        chk("R5 fetch busy length", n, RD_CYC);
        chk("R6 R3 R1 fetched byte", v, VEC[i][7:0]);
      end
    end

    // R9 readback
    wr(2'd1, 8'h42); wr(2'd0, 8'h99);
    rd(2'd1, v); chk("R9 address readback", v, 8'h42);
    rd(2'd0, v); chk("R9 data readback", v, 8'h99);

    // R4 control write with start clear starts nothing
    wr(2'd2, 8'h40);
    chk("R4 no busy without start", busy, 0);
    repeat (2) @(negedge clk);
    chk("R4 still idle", busy, 0);
    rd(2'd2, v); chk("R4 direction recorded", v, 8'h40);

    // R7 writes during a store are ignored
    do_store(8'h20, 8'h33, 1'b0);
    wr(2'd0, 8'h22); wr(2'd1, 8'h10); wr(2'd2, 8'h80);
    wr(2'd0, 8'h77); wr(2'd1, 8'h20); wr(2'd2, 8'hC0);
    busy_len(n);
    rd(2'd1, v); chk("R7 address held", v, 8'h10);
    rd(2'd0, v); chk("R7 data held", v, 8'h22);
    rd(2'd2, v); chk("R7 no second start", v, 8'h00);
    do_fetch(8'h10, v, n); chk("R7 stored original byte", v, 8'h22);
    do_fetch(8'h20, v, n); chk("R7 other location untouched", v, 8'h33);

    // R8 reset mid-transfer, array kept
    wr(2'd0, 8'hEE); wr(2'd1, 8'h55); wr(2'd2, 8'h80);
    chk("R8 busy before reset", busy, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 busy cleared mid-transfer", busy, 0);
    rd(2'd2, v); chk("R8 ctrl cleared", v, 8'h00);
    do_fetch(8'hFF, v, n); chk("R8 array kept across reset", v, 8'h3C);
    do_fetch(8'h10, v, n); chk("R8 array kept second location", v, 8'h22);

    finish_run();
  end
endmodule